// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block keeps a small burst-mode register and turns one burst request into a stream of column addresses. It produces one address per clock. A controller writes the register by pulsing `mode_load` with a 12-bit word on `mode_bus`. It then starts each read or write burst by pulsing `burst_start` with the first column on `start_col`. From the next cycle the block drives `col_valid` and `col_addr` for the programmed number of beats. It raises `col_last` on the final beat and stops early when `burst_stop` is seen.

Fixed-length bursts of 2, 4 or 8 stay inside the aligned block of columns that holds the starting column and wrap at its edge. The order inside the block is either a modulo increment or the starting offset XOR a beat count. A full-row burst walks the whole row from the starting column, wraps at its end and runs until it is stopped. A write-single option cuts every write burst to one beat. The latency field is decoded and exported only. Codes that are reserved or unsupported fall back to single-beat bursts and raise an error flag.

Top module: `sdr_burst_seq`

## Requirements
- R1: After a synchronous active-low reset, `col_valid` is 0 and `mode_err` is 0. `cas_lat3` is 0. The mode acts as burst length 1, sequential, programmed-length writes.
- R2: A `mode_load` pulse captures `mode_bus` at that clock edge. Bits [2:0] select the length: 000=1, 001=2, 010=4, 011=8, 111=full row. Bit 3 selects interleaved when 1. Bits [6:4] hold the latency. Bits [8:7] must be 00, and a nonzero value there sets `mode_err`. Bit 9 is write-single. Bits [11:10] have no effect.
- R3: A `burst_start` pulse gives `col_valid`=1 and `col_addr`=`start_col` on the next cycle. For sequential lengths 2, 4 and 8, the low 1, 2 or 3 bits step up by one each cycle and wrap inside the aligned block. The upper bits stay fixed.
- R4: In interleaved mode, the low bits of beat k equal the starting low bits XOR k.
- R5: A full-row burst steps the whole column up by one each cycle, wrapping from all-ones to zero. It never raises `col_last`. Full row combined with interleaved (code 1111 in bits [3:0]) is unsupported.
- R6: With length 1, exactly one beat at `start_col` is produced, whatever bit 3 holds.
- R7: `col_last` is 1 only on the final beat of a fixed-length burst. `col_valid` is 0 on the next cycle unless a new burst starts.
- R8: When `burst_stop` is high during a beat, `col_valid` is 0 on the next cycle. `burst_start` takes priority over `burst_stop`.
- R9: When bit 9 is 1, a burst with `burst_write`=1 has one beat. A read burst still uses the programmed length.
- R10: A reserved length code, the unsupported full-row interleaved code, a reserved latency code or nonzero bits [8:7] makes bursts length 1. Such a load sets `mode_err`, which stays set until a load with a valid word.
- R11: `cas_lat3` is 1 after loading latency code 011 and 0 after code 010 or a reserved code.
- R12: A burst keeps the mode it was started with, even if the register is reloaded during the burst. A `burst_start` during a burst restarts at the new column on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_load | input | 1 | Write strobe for the mode register |
| mode_bus | input | 12 | Mode word |
| burst_start | input | 1 | Start a burst at `start_col` |
| burst_write | input | 1 | The burst being started is a write |
| start_col | input | COL_W | First column of the burst |
| burst_stop | input | 1 | End the running burst after the current beat |
| col_valid | output | 1 | A column address is presented |
| col_addr | output | COL_W | Current column address |
| col_last | output | 1 | Final beat of a fixed-length burst |
| cas_lat3 | output | 1 | Decoded latency: 1 for three cycles, 0 for two |
| mode_err | output | 1 | Last loaded mode word was reserved or unsupported |

## Verification
The address sequence is tried with starting offsets in the middle of a block, at the top of a block and at zero. This separates wrap-inside-the-block from carry into the upper bits. The same start column is run in sequential and in interleaved order, so a swapped or missing XOR shows up at the second beat. A full-row run that crosses the all-ones column checks the row-wide wrap against the block-wide wrap. Reloading during a burst, restarting and stopping early are checked separately. Reads and writes under the write-single bit are compared, as are each class of bad mode word.

// File: rtl/sdr_burst_pkg.sv
// Package: shared types and field positions for the burst column sequencer.
// Assumes the mode word is 12 bits wide with fixed field positions.
package sdr_burst_pkg;

    typedef enum logic [2:0] {
        BL_ONE   = 3'd0,
        BL_TWO   = 3'd1,
        BL_FOUR  = 3'd2,
        BL_EIGHT = 3'd3,
        BL_ROW   = 3'd7
    } blen_e;

    typedef struct packed {
        blen_e len;
        logic  ilv;
        logic  lat3;
        logic  wr_single;
    } mode_t;

    localparam int MODE_W   = 12;
    localparam int F_LEN_LO = 0;
    localparam int F_TYPE   = 3;
    localparam int F_LAT_LO = 4;
    localparam int F_OP_LO  = 7;
    localparam int F_WB     = 9;

    localparam mode_t MODE_RST = '{len: BL_ONE, ilv: 1'b0, lat3: 1'b0, wr_single: 1'b0};

endpackage

// File: rtl/sdr_mode_reg.sv
// Module: sdr_mode_reg
// Decodes and holds the burst mode word. Any reserved or unsupported field
// makes the stored length single-beat and sets the error flag.
// Assumes: load is a one-cycle strobe; word bits above the write-single bit are don't-care.
module sdr_mode_reg
    import sdr_burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MODE_W-1:0] word,
    output mode_t             mode_q,
    output logic              err_q
);

    logic [2:0] len_code;
    logic [2:0] lat_code;
    logic       len_ok;
    logic       lat_ok;
    logic       op_ok;
    logic       bad;
    mode_t      dec;

    // Check each field of the incoming word and build the decoded mode.
    always_comb begin
        len_code = word[F_LEN_LO +: 3];
        lat_code = word[F_LAT_LO +: 3];
        unique case (len_code)
            3'b000, 3'b001, 3'b010, 3'b011: len_ok = 1'b1;
            3'b111:                         len_ok = !word[F_TYPE];
            default:                        len_ok = 1'b0;
        endcase
        lat_ok        = (lat_code == 3'b010) || (lat_code == 3'b011);
        op_ok         = (word[F_OP_LO +: 2] == 2'b00);
        bad           = !(len_ok && lat_ok && op_ok);
        dec.len       = bad ? BL_ONE : blen_e'(len_code);
        dec.ilv       = word[F_TYPE];
        dec.lat3      = lat_ok && (lat_code == 3'b011);
        dec.wr_single = word[F_WB];
    end

    // Store the decoded mode and the error flag on a load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RST;
            err_q  <= 1'b0;
        end else if (load) begin
            mode_q <= dec;
            err_q  <= bad;
        end
    end

endmodule

// File: rtl/sdr_burst_ctl.sv
// Module: sdr_burst_ctl
// Captures the burst setup at start and runs the beat counter.
// It decides when the burst ends: on the last beat of a fixed length or on a stop.
// Assumes: COL_W >= 3 so an eight-beat block fits in a row.
module sdr_burst_ctl
    import sdr_burst_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_wr,
    input  logic [COL_W-1:0] start_col,
    input  logic             stop,
    input  mode_t            mode,
    output logic             active,
    output logic [COL_W-1:0] cnt,
    output logic [COL_W-1:0] base,
    output logic [COL_W-1:0] mask,
    output logic             ilv,
    output logic             last
);

    localparam logic [COL_W-1:0] ROW_MASK = {COL_W{1'b1}};

    logic [COL_W-1:0] mask_d;
    logic             full_d;
    logic             full_q;

    // Turn the stored length and the write override into a wrap mask.
    always_comb begin
        unique case (mode.len)
            BL_TWO:   mask_d = COL_W'(1);
            BL_FOUR:  mask_d = COL_W'(3);
            BL_EIGHT: mask_d = COL_W'(7);
            BL_ROW:   mask_d = ROW_MASK;
            default:  mask_d = '0;
        endcase
        full_d = (mode.len == BL_ROW);
        if (is_wr && mode.wr_single) begin
            mask_d = '0;
            full_d = 1'b0;
        end
    end

    // The final beat of a fixed-length burst is reached when the count hits the mask.
    always_comb begin
        last = active && !full_q && (cnt == mask);
    end

    // Start, advance and end the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            base   <= '0;
            mask   <= '0;
            ilv    <= 1'b0;
            full_q <= 1'b0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
            base   <= start_col;
            mask   <= mask_d;
            ilv    <= mode.ilv;
            full_q <= full_d;
        end else if (active) begin
            if (stop || last) begin
                active <= 1'b0;
            end else begin
                cnt <= cnt + COL_W'(1);
            end
        end
    end

endmodule

// File: rtl/sdr_col_map.sv
// Module: sdr_col_map
// Combinational map from the start column and beat count to the column address.
// Bits above the mask stay fixed. Bits under it follow sequential or XOR order.
// Assumes: cnt never exceeds mask, so the XOR stays inside the block.
module sdr_col_map #(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] cnt,
    input  logic [COL_W-1:0] mask,
    input  logic             ilv,
    output logic [COL_W-1:0] addr
);

    logic [COL_W-1:0] seq_off;
    logic [COL_W-1:0] ilv_off;
    logic [COL_W-1:0] off;

    // Choose the in-block offset and join it with the fixed upper bits.
    always_comb begin
        seq_off = base + cnt;
        ilv_off = base ^ cnt;
        off     = ilv ? ilv_off : seq_off;
        addr    = (base & ~mask) | (off & mask);
    end

endmodule

// File: rtl/sdr_burst_seq.sv
// Module: sdr_burst_seq (top)
// Mode register plus burst column sequencer. It emits one column per clock from
// the cycle after burst_start.
// Assumes: a burst started in the same cycle as a mode load uses the old mode.
module sdr_burst_seq
    import sdr_burst_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_load,
    input  logic [11:0]      mode_bus,
    input  logic             burst_start,
    input  logic             burst_write,
    input  logic [COL_W-1:0] start_col,
    input  logic             burst_stop,
    output logic             col_valid,
    output logic [COL_W-1:0] col_addr,
    output logic             col_last,
    output logic             cas_lat3,
    output logic             mode_err
);

    mode_t            mode_q;
    logic             active;
    logic [COL_W-1:0] cnt;
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] mask;
    logic             ilv;
    logic             last;

    sdr_mode_reg u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (mode_load),
        .word   (mode_bus),
        .mode_q (mode_q),
        .err_q  (mode_err)
    );

    sdr_burst_ctl #(.COL_W(COL_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (burst_start),
        .is_wr     (burst_write),
        .start_col (start_col),
        .stop      (burst_stop),
        .mode      (mode_q),
        .active    (active),
        .cnt       (cnt),
        .base      (base),
        .mask      (mask),
        .ilv       (ilv),
        .last      (last)
    );

    sdr_col_map #(.COL_W(COL_W)) u_map (
        .base (base),
        .cnt  (cnt),
        .mask (mask),
        .ilv  (ilv),
        .addr (col_addr)
    );

    // Drive the handshake outputs from the controller and mode register.
    always_comb begin
        col_valid = active;
        col_last  = last;
        cas_lat3  = mode_q.lat3;
    end

endmodule

// File: rtl/sdr_burst_seq_chk.sv
// Module: sdr_burst_seq_chk
// Port-level properties of the sequencer, attached to the top by bind.
// Assumes: it is bound only to sdr_burst_seq.
module sdr_burst_seq_chk #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_load,
    input logic             burst_start,
    input logic             burst_stop,
    input logic [COL_W-1:0] start_col,
    input logic             col_valid,
    input logic [COL_W-1:0] col_addr,
    input logic             col_last,
    input logic             cas_lat3,
    input logic             mode_err
);

    AST_START_FIRST_COL: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |=> (col_valid && col_addr == $past(start_col))); // R3

    AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid); // R7

    AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (col_last && !burst_start) |=> !col_valid); // R7

    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && burst_stop && !burst_start) |=> !col_valid); // R8

    AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_load |=> $stable(mode_err)); // R10

    AST_LAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_load |=> $stable(cas_lat3)); // R11

endmodule

bind sdr_burst_seq sdr_burst_seq_chk #(.COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_load   (mode_load),
    .burst_start (burst_start),
    .burst_stop  (burst_stop),
    .start_col   (start_col),
    .col_valid   (col_valid),
    .col_addr    (col_addr),
    .col_last    (col_last),
    .cas_lat3    (cas_lat3),
    .mode_err    (mode_err)
);

// File: tb/sdr_burst_seq_tb.sv
module sdr_burst_seq_tb;

    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_load = 1'b0;
    logic [11:0]      mode_bus = '0;
    logic             burst_start = 1'b0;
    logic             burst_write = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic             burst_stop = 1'b0;
    logic             col_valid;
    logic [COL_W-1:0] col_addr;
    logic             col_last;
    logic             cas_lat3;
    logic             mode_err;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    sdr_burst_seq #(.COL_W(COL_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_load   (mode_load),
        .mode_bus    (mode_bus),
        .burst_start (burst_start),
        .burst_write (burst_write),
        .start_col   (start_col),
        .burst_stop  (burst_stop),
        .col_valid   (col_valid),
        .col_addr    (col_addr),
        .col_last    (col_last),
        .cas_lat3    (cas_lat3),
        .mode_err    (mode_err)
    );

    typedef struct packed {
        logic [11:0]         mode;
        logic [9:0]          col;
        logic                wr;
        logic [3:0]          n;
        logic [0:7][9:0]     seq;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        // R3 sequential 8, start offset 5
        '{12'h023, 10'h0D5, 1'b0, 4'd8, {10'h0D5,10'h0D6,10'h0D7,10'h0D0,10'h0D1,10'h0D2,10'h0D3,10'h0D4}},
        // R4 interleaved 8, start offset 5
        '{12'h02B, 10'h0D5, 1'b0, 4'd8, {10'h0D5,10'h0D4,10'h0D7,10'h0D6,10'h0D1,10'h0D0,10'h0D3,10'h0D2}},
        // R3 sequential 4, start offset 2
        '{12'h022, 10'h20E, 1'b0, 4'd4, {10'h20E,10'h20F,10'h20C,10'h20D,10'h0,10'h0,10'h0,10'h0}},
        // R4 interleaved 4, start offset 3
        '{12'h02A, 10'h20F, 1'b0, 4'd4, {10'h20F,10'h20E,10'h20D,10'h20C,10'h0,10'h0,10'h0,10'h0}},
        // R3 sequential 2 at top of row, no carry out of block
        '{12'h021, 10'h3FF, 1'b0, 4'd2, {10'h3FF,10'h3FE,10'h0,10'h0,10'h0,10'h0,10'h0,10'h0}},
        // R4 interleaved 2, start offset 0
        '{12'h029, 10'h100, 1'b0, 4'd2, {10'h100,10'h101,10'h0,10'h0,10'h0,10'h0,10'h0,10'h0}},
        // R6 length 1 with interleave bit set
        '{12'h028, 10'h155, 1'b0, 4'd1, {10'h155,10'h0,10'h0,10'h0,10'h0,10'h0,10'h0,10'h0}},
        // R9 write-single: write gives one beat
        '{12'h223, 10'h0D5, 1'b1, 4'd1, {10'h0D5,10'h0,10'h0,10'h0,10'h0,10'h0,10'h0,10'h0}},
        // R9 write-single: read keeps length 8
        '{12'h223, 10'h0D5, 1'b0, 4'd8, {10'h0D5,10'h0D6,10'h0D7,10'h0D0,10'h0D1,10'h0D2,10'h0D3,10'h0D4}},
        // R2 upper bits [11:10] ignored, latency 3
        '{12'hC33, 10'h001, 1'b0, 4'd8, {10'h001,10'h002,10'h003,10'h004,10'h005,10'h006,10'h007,10'h000}}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_mode(input logic [11:0] w);
        mode_load = 1'b1;
        mode_bus  = w;
        @(negedge clk);
        mode_load = 1'b0;
    endtask

    task automatic start_burst(input logic [COL_W-1:0] c, input logic wr);
        burst_start = 1'b1;
        start_col   = c;
        burst_write = wr;
        @(negedge clk);
        burst_start = 1'b0;
        burst_write = 1'b0;
    endtask

    task automatic stop_now();
        burst_stop = 1'b1;
        @(negedge clk);
        burst_stop = 1'b0;
    endtask

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 valid", 32'(col_valid), 0);
        check("R1 err", 32'(mode_err), 0);
        check("R1 lat3", 32'(cas_lat3), 0);
        start_burst(10'h123, 1'b0);
        check("R1 default beat", 32'(col_addr), 32'h123);
        check("R1 default last", 32'(col_last), 1);
        @(negedge clk);
        check("R1 default single", 32'(col_valid), 0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            load_mode(VECS[v].mode);
            check($sformatf("VEC%0d R2 err", v), 32'(mode_err), 0);
            start_burst(VECS[v].col, VECS[v].wr);
            for (int i = 0; i < int'(VECS[v].n); i++) begin
                check($sformatf("VEC%0d beat%0d valid", v, i), 32'(col_valid), 1);
                check($sformatf("VEC%0d beat%0d addr", v, i), 32'(col_addr), 32'(VECS[v].seq[i]));
                check($sformatf("VEC%0d beat%0d R7 last", v, i), 32'(col_last),
                      32'(i == int'(VECS[v].n) - 1));
                @(negedge clk);
            end
            check($sformatf("VEC%0d R7 idle", v), 32'(col_valid), 0);
        end
        check("R11 lat3 after code 011", 32'(cas_lat3), 1);

        // R5 full row wraps across the row until stopped; R8 stop
        load_mode(12'h027);
        check("R5 err", 32'(mode_err), 0);
        check("R11 lat3 after code 010", 32'(cas_lat3), 0);
        start_burst(10'h3FD, 1'b0);
        for (int i = 0; i < 6; i++) begin
            check("R5 row valid", 32'(col_valid), 1);
            check("R5 row addr", 32'(col_addr), 32'((10'h3FD + 10'(i)) & 10'h3FF));
            check("R5 row no last", 32'(col_last), 0);
            if (i < 5) @(negedge clk);
        end
        stop_now();
        check("R8 row stopped", 32'(col_valid), 0);

        // R8 stop on a fixed-length burst
        load_mode(12'h023);
        start_burst(10'h0D5, 1'b0);
        @(negedge clk);
        check("R8 beat1", 32'(col_addr), 32'h0D6);
        stop_now();
        check("R8 fixed stopped", 32'(col_valid), 0);

        // R12 reload during burst does not affect it
        start_burst(10'h040, 1'b0);
        check("R12 beat0", 32'(col_addr), 32'h040);
        load_mode(12'h021);
        for (int i = 1; i < 8; i++) begin
            check("R12 kept mode addr", 32'(col_addr), 32'h040 + 32'(i));
            check("R12 kept mode last", 32'(col_last), 32'(i == 7));
            @(negedge clk);
        end
        check("R12 end", 32'(col_valid), 0);

        // R12 restart during a burst, mode now length 2
        start_burst(10'h010, 1'b0);
        check("R12 first", 32'(col_addr), 32'h010);
        burst_stop = 1'b1;
        start_burst(10'h020, 1'b0);
        burst_stop = 1'b0;
        check("R12 R8 restart valid", 32'(col_valid), 1);
        check("R12 restart addr", 32'(col_addr), 32'h020);
        @(negedge clk);
        check("R12 restart beat1", 32'(col_addr), 32'h021);
        check("R12 restart last", 32'(col_last), 1);
        @(negedge clk);

        // R10 reserved length code
        load_mode(12'h024);
        check("R10 reserved len err", 32'(mode_err), 1);
        start_burst(10'h0D5, 1'b0);
        check("R10 single beat last", 32'(col_last), 1);
        @(negedge clk);
        check("R10 single beat end", 32'(col_valid), 0);
        @(negedge clk);
        check("R10 err held", 32'(mode_err), 1);

        // R5 full row with interleave is unsupported
        load_mode(12'h02F);
        check("R5 row ilv err", 32'(mode_err), 1);
        start_burst(10'h0D5, 1'b0);
        check("R5 row ilv single", 32'(col_last), 1);
        @(negedge clk);
        check("R5 row ilv end", 32'(col_valid), 0);

        // R10 valid load clears the error
        load_mode(12'h030);
        check("R10 err cleared", 32'(mode_err), 0);
        check("R11 lat3 code 011", 32'(cas_lat3), 1);

        // R11 reserved latency code
        load_mode(12'h053);
        check("R11 reserved lat err", 32'(mode_err), 1);
        check("R11 reserved lat3", 32'(cas_lat3), 0);
        start_burst(10'h0D5, 1'b0);
        check("R10 reserved lat single", 32'(col_last), 1);
        @(negedge clk);

        // R2 nonzero operating-mode bits
        load_mode(12'h0A3);
        check("R2 op bits err", 32'(mode_err), 1);
        load_mode(12'h020);
        check("R2 valid again", 32'(mode_err), 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule